// File: doc/BRIEF.md
# Cached Word Writer with Signed Multiplier

This unit sits beside a byte-wide video memory port. A CPU uses a small bank of byte registers to set a byte address and an increment step, then reads or writes a data port. Each data port access moves the address on by the step. Normally a store to the port writes one byte.

Four bank registers share their addresses. A select value picks what they mean. With select 6 they load the four bytes of a 32-bit cache. With select 2 they hold a mode register, a nibble mask and a multiply-control register. When the cache-write bit is on, one store to the data port becomes a 32-bit write of the whole cache to the aligned word. The CPU byte is not used, and any nibble whose mask bit is set is held back. When multiply is also on, the written word is the full signed 32-bit product of the cache's two 16-bit halves.

The write reaches memory one cycle after the store. This gives the registered product time to settle from the cache.

Top module: `vwm_top`

## Requirements
- R1: After reset, every register reads back 0 (select 0, cache write off, multiply off, mask 0 so all nibbles are enabled), and `memWe` is low.
- R2: With select 6 (write 0x0C to index 4, select held in bits 6:1), writes to indices 5, 6, 7, 8 load cache bytes 0 to 3, which are word bits 7:0, 15:8, 23:16 and 31:24.
- R3: With select 2 (0x04 to index 4), bit 6 of index 5 enables cache write. A data port store then writes the cache word, whatever the CPU byte is. Writing 0 to index 5 returns the port to byte writes.
- R4: With select 2, writing 0x10 to index 8 (bit 4) enables multiply. Cache writes then store the signed product of cache bits 15:0 and cache bits 31:16, with all 32 bits exact (for example 0x7FFF×0x4000 = 0x1FFFC000).
- R5: With select 2, index 6 is a nibble mask. When bit k is set, nibble k (word bits 4k+3:4k) is suppressed on a cache write. `memNibEn` equals the inverted mask.
- R6: A cache write targets the aligned word: `memWrAddr` bits 1:0 are 0 and the upper bits equal the current address.
- R7: With cache write off, a port store writes the CPU byte replicated on all four lanes. Only the two nibbles of lane addr[1:0] are enabled (nibble enables 2·lane and 2·lane+1).
- R8: Index 0 and index 1 hold address bits 7:0 and 15:8. Index 2 bit 0 holds address bit 16, and index 2 bits 5:4 hold a step code: 0→0, 1→1, 2→2, 3→4. Every data port read or write adds the step to the 17-bit address, which wraps modulo 2^17. With no access, the address holds.
- R9: A data port read (index 3) returns `memRdByte` for the current address, regardless of the cache-write and multiply settings, and issues no memory write.
- R10: `memWe` is a single-cycle pulse in the cycle after a data port store, and it never appears otherwise.
- R11: Writes to indices 5 to 8 under a select other than 2 or 6 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuWe | input | 1 | CPU register write strobe |
| cpuRe | input | 1 | CPU register read strobe |
| cpuAddr | input | 4 | Register index |
| cpuWrData | input | 8 | CPU write byte |
| cpuRdData | output | 8 | CPU read byte (combinational) |
| memRdAddr | output | 17 | Current byte address for memory reads |
| memRdByte | input | 8 | Byte read from memory at `memRdAddr` |
| memWe | output | 1 | Memory write strobe |
| memWrAddr | output | 17 | Memory write byte address |
| memWrData | output | 32 | Memory write word |
| memNibEn | output | 8 | Per-nibble write enables |

## Verification
The bench builds the block with its package defaults: a 17-bit byte address, a four-byte cache and a two-bit step code. At that address width the last aligned word is reachable with three register writes. This lets the bench drive the address counter across its wrap to zero under the 4-byte step. The 16-bit operand width puts the signed extremes (0x8000, 0x7FFF, 0xFFFF) within reach, along with the middle product bits, which are checked with exact directed values and random pairs.

// File: rtl/vwm_pkg.sv
package vwm_pkg;
  localparam int ADDR_W  = 17;
  localparam int BYTE_W  = 8;
  localparam int NBYTES  = 4;
  localparam int WORD_W  = BYTE_W * NBYTES;
  localparam int NIBS    = WORD_W / 4;
  localparam int HALF_W  = WORD_W / 2;
  localparam int IDX_W   = 4;
  localparam int LANE_W  = $clog2(NBYTES);

  localparam logic [IDX_W-1:0] IDX_ADDR_L = 4'd0;
  localparam logic [IDX_W-1:0] IDX_ADDR_M = 4'd1;
  localparam logic [IDX_W-1:0] IDX_ADDR_H = 4'd2;
  localparam logic [IDX_W-1:0] IDX_PORT   = 4'd3;
  localparam logic [IDX_W-1:0] IDX_SEL    = 4'd4;
  localparam logic [IDX_W-1:0] IDX_BANK0  = 4'd5;
  localparam logic [IDX_W-1:0] IDX_BANKN  = 4'd8;

  localparam logic [5:0] SEL_CTRL  = 6'd2;
  localparam logic [5:0] SEL_CACHE = 6'd6;

  typedef struct packed {
    logic              cacheLd;
    logic [LANE_W-1:0] cacheIdx;
    logic              portWr;
    logic              wide;
    logic              mul;
    logic [LANE_W-1:0] lane;
  } strobe_t;

  function automatic logic [ADDR_W-1:0] stepOf(input logic [1:0] code);
    case (code)
      2'd0:    stepOf = '0;
      2'd1:    stepOf = ADDR_W'(1);
      2'd2:    stepOf = ADDR_W'(2);
      default: stepOf = ADDR_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/vwm_ctrl.sv
module vwm_ctrl
  import vwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWe,
  input  logic              cpuRe,
  input  logic [IDX_W-1:0]  cpuAddr,
  input  logic [BYTE_W-1:0] cpuWrData,
  input  logic [BYTE_W-1:0] memRdByte,
  output logic [BYTE_W-1:0] cpuRdData,
  output logic [ADDR_W-1:0] curAddr,
  output logic [NIBS-1:0]   nibMask,
  output strobe_t           strb
);
  logic [ADDR_W-1:0] addrQ;
  logic [6:0]        ctlHiQ;
  logic [BYTE_W-1:0] selQ, modeQ, maskQ, mulQ;
  logic [5:0]        sel;
  logic              portHit, bankHit, portAccess;
  logic [LANE_W-1:0] bankIdx;

  assign sel        = selQ[6:1];
  assign portHit    = (cpuAddr == IDX_PORT);
  assign bankHit    = (cpuAddr >= IDX_BANK0) && (cpuAddr <= IDX_BANKN);
  assign bankIdx    = cpuAddr[LANE_W-1:0] - LANE_W'(1);
  assign portAccess = portHit && (cpuWe || cpuRe);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      ctlHiQ <= '0;
      selQ   <= '0;
      modeQ  <= '0;
      maskQ  <= '0;
      mulQ   <= '0;
    end else begin
      if (cpuWe) begin
        case (cpuAddr)
          IDX_ADDR_L: addrQ[7:0]  <= cpuWrData;
          IDX_ADDR_M: addrQ[15:8] <= cpuWrData;
          IDX_ADDR_H: begin
            addrQ[16] <= cpuWrData[0];
            ctlHiQ    <= cpuWrData[7:1];
          end
          IDX_SEL:    selQ <= cpuWrData;
          default: begin
            if (bankHit && sel == SEL_CTRL) begin
              case (bankIdx)
                2'd0:    modeQ <= cpuWrData;
                2'd1:    maskQ <= cpuWrData;
                2'd3:    mulQ  <= cpuWrData;
                default: ;
              endcase
            end
          end
        endcase
      end
      if (portAccess) addrQ <= addrQ + stepOf(ctlHiQ[4:3]);
    end
  end

  always_comb begin
    cpuRdData = '0;
    case (cpuAddr)
      IDX_ADDR_L: cpuRdData = addrQ[7:0];
      IDX_ADDR_M: cpuRdData = addrQ[15:8];
      IDX_ADDR_H: cpuRdData = {ctlHiQ, addrQ[16]};
      IDX_PORT:   cpuRdData = memRdByte;
      IDX_SEL:    cpuRdData = selQ;
      default: begin
        if (bankHit && sel == SEL_CTRL) begin
          case (bankIdx)
            2'd0:    cpuRdData = modeQ;
            2'd1:    cpuRdData = maskQ;
            2'd3:    cpuRdData = mulQ;
            default: cpuRdData = '0;
          endcase
        end
      end
    endcase
  end

  always_comb begin
    strb.cacheLd  = cpuWe && bankHit && (sel == SEL_CACHE);
    strb.cacheIdx = bankIdx;
    strb.portWr   = cpuWe && portHit;
    strb.wide     = modeQ[6];
    strb.mul      = mulQ[4];
    strb.lane     = addrQ[LANE_W-1:0];
  end

  assign curAddr = addrQ;
  assign nibMask = maskQ;
endmodule

// File: rtl/vwm_datapath.sv
module vwm_datapath
  import vwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [BYTE_W-1:0] cpuWrData,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic [NIBS-1:0]   nibMask,
  output logic              memWe,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [WORD_W-1:0] memWrData,
  output logic [NIBS-1:0]   memNibEn
);
  logic [NBYTES-1:0][BYTE_W-1:0] cacheQ;
  logic signed [HALF_W-1:0]      opLo, opHi;
  logic signed [WORD_W-1:0]      prodQ;
  logic [WORD_W-1:0]             dataQ;
  logic                          useProdQ;
  logic [NIBS-1:0]               laneNib;

  for (genvar b = 0; b < NBYTES; b++) begin : g_cache
    always_ff @(posedge clk) begin
      if (!rstN) cacheQ[b] <= '0;
      else if (strb.cacheLd && strb.cacheIdx == LANE_W'(b)) cacheQ[b] <= cpuWrData;
    end
  end

  for (genvar n = 0; n < NIBS; n++) begin : g_nib
    assign laneNib[n] = (strb.lane == LANE_W'(n / 2));
  end

  assign opLo = $signed(cacheQ[1:0]);
  assign opHi = $signed(cacheQ[3:2]);

  always_ff @(posedge clk) begin
    if (!rstN) prodQ <= '0;
    else       prodQ <= opLo * opHi;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memWe     <= 1'b0;
      memWrAddr <= '0;
      dataQ     <= '0;
      useProdQ  <= 1'b0;
      memNibEn  <= '0;
    end else begin
      memWe <= strb.portWr;
      if (strb.portWr) begin
        if (strb.wide) begin
          memWrAddr <= {curAddr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
          dataQ     <= cacheQ;
          useProdQ  <= strb.mul;
          memNibEn  <= ~nibMask;
        end else begin
          memWrAddr <= curAddr;
          dataQ     <= {NBYTES{cpuWrData}};
          useProdQ  <= 1'b0;
          memNibEn  <= laneNib;
        end
      end
    end
  end

  assign memWrData = useProdQ ? prodQ : dataQ;
endmodule

// File: rtl/vwm_top.sv
module vwm_top
  import vwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWe,
  input  logic              cpuRe,
  input  logic [IDX_W-1:0]  cpuAddr,
  input  logic [BYTE_W-1:0] cpuWrData,
  output logic [BYTE_W-1:0] cpuRdData,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [BYTE_W-1:0] memRdByte,
  output logic              memWe,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [WORD_W-1:0] memWrData,
  output logic [NIBS-1:0]   memNibEn
);
  strobe_t           strobes;
  logic [NIBS-1:0]   maskBits;
  logic [ADDR_W-1:0] curAddr;

  vwm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cpuWe(cpuWe), .cpuRe(cpuRe), .cpuAddr(cpuAddr),
    .cpuWrData(cpuWrData), .memRdByte(memRdByte), .cpuRdData(cpuRdData),
    .curAddr(curAddr), .nibMask(maskBits), .strb(strobes)
  );

  vwm_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strobes), .cpuWrData(cpuWrData),
    .curAddr(curAddr), .nibMask(maskBits), .memWe(memWe),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .memNibEn(memNibEn)
  );

  assign memRdAddr = curAddr;
endmodule

// File: rtl/vwm_checker.sv
module vwm_checker
  import vwm_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cpuWe,
  input logic              cpuRe,
  input logic [IDX_W-1:0]  cpuAddr,
  input logic [BYTE_W-1:0] cpuWrData,
  input logic [ADDR_W-1:0] memRdAddr,
  input logic              memWe,
  input logic [ADDR_W-1:0] memWrAddr,
  input logic [WORD_W-1:0] memWrData,
  input logic [NIBS-1:0]   memNibEn,
  input strobe_t           strb,
  input logic [NIBS-1:0]   mask
);
  assert_port_store_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWe && cpuAddr == IDX_PORT) |=> memWe);

  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuWe && cpuAddr == IDX_PORT) |=> !memWe);

  assert_wide_aligned_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.portWr && strb.wide) |=> (memWrAddr[1:0] == 2'b00));

  assert_wide_mask_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.portWr && strb.wide) |=> (memNibEn == ~$past(mask)));

  assert_byte_lane_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.portWr && !strb.wide) |=>
      ($countones(memNibEn) == 2 && memWrData[7:0] == $past(cpuWrData)));

  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuWe && !cpuRe) |=> $stable(memRdAddr));

  assert_read_nowrite_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRe && !cpuWe) |=> !memWe);
endmodule

bind vwm_top vwm_checker u_vwm_checker (
  .clk(clk), .rstN(rstN), .cpuWe(cpuWe), .cpuRe(cpuRe), .cpuAddr(cpuAddr),
  .cpuWrData(cpuWrData), .memRdAddr(memRdAddr), .memWe(memWe),
  .memWrAddr(memWrAddr), .memWrData(memWrData), .memNibEn(memNibEn),
  .strb(strobes), .mask(maskBits)
);

// File: tb/vwm_top_bench.sv
module vwm_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuWe = 1'b0, cpuRe = 1'b0;
  logic [3:0]  cpuAddr = '0;
  logic [7:0]  cpuWrData = '0;
  logic [7:0]  cpuRdData, memRdByte;
  logic [16:0] memRdAddr, memWrAddr;
  logic        memWe;
  logic [31:0] memWrData;
  logic [7:0]  memNibEn;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [16:0] expAddr;
  logic [16:0] expStep;
  logic [7:0]  curMask;
  bit          curMul;

  always #5 clk = ~clk;

  assign memRdByte = memRdAddr[7:0] ^ memRdAddr[16:9];

  vwm_top u_vwm_top (
    .clk(clk), .rstN(rstN), .cpuWe(cpuWe), .cpuRe(cpuRe), .cpuAddr(cpuAddr),
    .cpuWrData(cpuWrData), .cpuRdData(cpuRdData), .memRdAddr(memRdAddr),
    .memRdByte(memRdByte), .memWe(memWe), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .memNibEn(memNibEn)
  );

  function automatic logic [16:0] stepFor(input logic [1:0] c);
    return (c == 2'd3) ? 17'd4 : 17'(c);
  endfunction

  function automatic logic [31:0] prodOf(input logic [31:0] w);
    logic signed [15:0] a, b;
    logic signed [31:0] p;
    a = w[15:0];
    b = w[31:16];
    p = a * b;
    return p;
  endfunction

  function automatic logic [7:0] laneNib(input logic [1:0] lane);
    return 8'b11 << (2 * lane);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [7:0] d);
    @(negedge clk);
    cpuWe = 1'b1; cpuAddr = idx; cpuWrData = d;
    @(negedge clk);
    cpuWe = 1'b0;
  endtask

  task automatic rdReg(input logic [3:0] idx, input logic [7:0] exp, input string req);
    @(negedge clk);
    cpuRe = 1'b1; cpuAddr = idx;
    #1 check(cpuRdData == exp, req, cpuRdData, exp);
    @(negedge clk);
    cpuRe = 1'b0;
  endtask

  task automatic setAddr(input logic [16:0] a, input logic [1:0] code);
    wr(4'd0, a[7:0]);
    wr(4'd1, a[15:8]);
    wr(4'd2, {2'b00, code, 3'b000, a[16]});
    expAddr = a;
    expStep = stepFor(code);
  endtask

  task automatic loadCache(input logic [31:0] w);
    wr(4'd4, 8'h0C);
    for (int i = 0; i < 4; i++) wr(4'(5 + i), w[8*i +: 8]);
    wr(4'd4, 8'h04);
  endtask

  task automatic storeByte(input logic [7:0] d);
    wr(4'd3, d);
    check(memWe == 1'b1, "R10 byte store strobe", 32'(memWe), 32'd1);
    check(memWrAddr == expAddr, "R7 byte address", 32'(memWrAddr), 32'(expAddr));
    check(memWrData == {4{d}}, "R7 byte data", memWrData, {4{d}});
    check(memNibEn == laneNib(expAddr[1:0]), "R7 lane nibbles", 32'(memNibEn), 32'(laneNib(expAddr[1:0])));
    expAddr = expAddr + expStep;
    check(memRdAddr == expAddr, "R8 step advance", 32'(memRdAddr), 32'(expAddr));
  endtask

  task automatic storeWide(input logic [31:0] cache, input string req);
    logic [31:0] expD;
    expD = curMul ? prodOf(cache) : cache;
    wr(4'd3, 8'hEE);
    check(memWe == 1'b1, "R10 wide store strobe", 32'(memWe), 32'd1);
    check(memWrAddr == {expAddr[16:2], 2'b00}, "R6 aligned address", 32'(memWrAddr), 32'({expAddr[16:2], 2'b00}));
    check(memWrData == expD, req, memWrData, expD);
    check(memNibEn == ~curMask, "R5 nibble mask", 32'(memNibEn), 32'(~curMask));
    @(negedge clk);
    check(memWe == 1'b0, "R10 single pulse", 32'(memWe), 32'd0);
    expAddr = expAddr + expStep;
    check(memRdAddr == expAddr, "R8 step advance", 32'(memRdAddr), 32'(expAddr));
  endtask

  task automatic readPort(input string req);
    logic [7:0] e;
    e = expAddr[7:0] ^ expAddr[16:9];
    @(negedge clk);
    cpuRe = 1'b1; cpuAddr = 4'd3;
    #1 check(cpuRdData == e, req, cpuRdData, e);
    @(negedge clk);
    cpuRe = 1'b0;
    check(memWe == 1'b0, "R9 read issues no write", 32'(memWe), 32'd0);
    expAddr = expAddr + expStep;
    check(memRdAddr == expAddr, "R8 read advance", 32'(memRdAddr), 32'(expAddr));
  endtask

  initial begin : watchdog
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] w;
    void'($urandom(32'h5EED_1234));
    curMask = '0; curMul = 0; expAddr = '0; expStep = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check(memWe == 1'b0, "R1 memWe idle", 32'(memWe), 32'd0);
    for (int i = 0; i < 9; i++) if (i != 3) rdReg(4'(i), 8'h00, "R1 register reset");
    wr(4'd4, 8'h04);
    rdReg(4'd5, 8'h00, "R1 mode reset");
    rdReg(4'd6, 8'h00, "R1 mask reset");
    rdReg(4'd8, 8'h00, "R1 multiply reset");
    wr(4'd4, 8'h00);

    // R7 / R8 byte writes
    setAddr(17'h00102, 2'd1);
    rdReg(4'd2, 8'h10, "R8 step code readback");
    storeByte(8'hA5);
    storeByte(8'h3C);

    // R11 bank writes ignored under select 0
    wr(4'd5, 8'h40);
    wr(4'd8, 8'h10);
    storeByte(8'h77);
    wr(4'd4, 8'h04);
    rdReg(4'd5, 8'h00, "R11 mode unchanged");
    rdReg(4'd8, 8'h00, "R11 multiply unchanged");

    // R2 / R3 cache write
    loadCache(32'h44332211);
    wr(4'd5, 8'h40);
    setAddr(17'h00207, 2'd3);
    storeWide(32'h44332211, "R2 R3 cache word");
    curMask = 8'h0F; wr(4'd6, curMask);
    storeWide(32'h44332211, "R5 masked cache word");
    curMask = 8'h00; wr(4'd6, 8'h00);

    // R4 directed products
    wr(4'd8, 8'h10); curMul = 1;
    loadCache(32'h4000_7FFF); storeWide(32'h4000_7FFF, "R4 product 7fff*4000");
    check(prodOf(32'h4000_7FFF) == 32'h1FFFC000, "R4 model", prodOf(32'h4000_7FFF), 32'h1FFFC000);
    loadCache(32'h7FFF_5555); storeWide(32'h7FFF_5555, "R4 product 5555*7fff");
    loadCache(32'h5555_5555); storeWide(32'h5555_5555, "R4 product 5555*5555");
    loadCache(32'h8000_8000); storeWide(32'h8000_8000, "R4 product 8000*8000");
    loadCache(32'h7FFF_8000); storeWide(32'h7FFF_8000, "R4 product 8000*7fff");
    loadCache(32'hFFFF_FFFF); storeWide(32'hFFFF_FFFF, "R4 product ffff*ffff");

    // R9 reads unaffected by modes
    readPort("R9 read with multiply on");

    // R8 wrap at top of address space
    setAddr(17'h1FFFC, 2'd3);
    storeWide(32'hFFFF_FFFF, "R8 wrap store");
    check(memRdAddr == 17'h0, "R8 wrap to zero", 32'(memRdAddr), 32'd0);

    // R3 disable returns to byte writes
    wr(4'd8, 8'h00); curMul = 0;
    wr(4'd5, 8'h00);
    setAddr(17'h0F0F1, 2'd2);
    storeByte(8'h5A);
    readPort("R9 read with modes off");

    // random mix
    for (int n = 0; n < 40; n++) begin
      logic [1:0] code;
      w = $urandom;
      code = 2'($urandom_range(0, 3));
      loadCache(w);
      curMask = 8'($urandom);
      curMul = 1'($urandom);
      wr(4'd6, curMask);
      wr(4'd8, curMul ? 8'h10 : 8'h00);
      wr(4'd5, 8'h40);
      setAddr(17'($urandom), code);
      storeWide(w, curMul ? "R4 random product" : "R2 random cache");
      if (n % 4 == 0) readPort("R9 random read");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule